// File: doc/BRIEF.md
# Streaming Mirror-Symmetry Mismatch Scanner

The block watches a stream of small symbols, one per clock when the input valid is high. It keeps the most recent WIN symbols in a shift register. For every window that a new symbol completes, it measures how far the window is from mirror symmetry about its centre. Each half-length j, from 1 up to H = WIN/2, pairs the symbol j places left of the centre with the symbol j places right of it. A mismatching pair adds one to the count for that half-length and for every longer one.

The pair compares are made in a single registered stage. A chain of H adder stages then sums them, one stage per clock. Stage j completes the count for half-length j. All H counts leave the block together, with a flag per half-length that is set when the count is at or below a threshold. The threshold and the compare mode (plain equality, or complement pairing for nucleotide streams) are taken with the symbol that completes the window. They travel down the pipeline with that window, so every result uses its own settings. The index of the window's oldest symbol is delayed by the same depth as the counts.

Top module: `pal_mirror_scan`

## Requirements
- R1: After reset, out_valid stays low until WIN symbols have been accepted. The first result belongs to the WIN-th accepted symbol.
- R2: Each accepted symbol that completes a full window produces exactly one out_valid cycle, on the (H+2)-th rising edge after the edge that accepted it. A cycle with in_valid low neither shifts the window nor produces a result.
- R3: Name the window symbols w[0] (oldest) to w[WIN-1] (newest). The count for half-length j is the number of k in 1..j for which w[H-k] and w[H+k-1] mismatch. It is output on out_count bits [(j-1)*CW +: CW], with CW = clog2(H+1).
- R4: With in_comp low for the completing symbol, two symbols mismatch when their codes differ.
- R5: With in_comp high for the completing symbol, two symbols match only when one code is the bitwise inverse of the other. With 2-bit codes A=00, C=01, G=10, T=11, this pairs A with T and C with G.
- R6: out_flag bit j-1 is high exactly when the count for half-length j is at or below the in_thresh value presented with the completing symbol.
- R7: out_start gives the index of w[0]. Indices number the accepted symbols from 0 after reset, modulo 2^IDX_W.
- R8: Within one result, the counts never decrease as j grows, and each step is 0 or 1.
- R9: A synchronous reset in the middle of a stream discards every result still in flight. No out_valid follows it until a new full window has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A symbol is presented this cycle |
| in_sym | input | SYM_W | Symbol code |
| in_comp | input | 1 | Complement pairing for the window this symbol completes |
| in_thresh | input | CW | Mismatch threshold for the window this symbol completes |
| out_valid | output | 1 | Result outputs are valid |
| out_start | output | IDX_W | Index of the oldest symbol of the reported window |
| out_count | output | H*CW | Mismatch count per half-length, half-length j in slot j-1 |
| out_flag | output | H | Bit j-1 set when the count for half-length j is within threshold |

## Verification
Up to H+2 windows are in flight at once. When symbols arrive back to back, each pipeline stage holds a different window in the same cycle, and each of those windows may carry a different mode and threshold. The bench changes mode and threshold on every symbol and inserts random gaps in the valid input. It checks every output cycle against a result computed from its own symbol history, so a setting that leaks from one window into its neighbour shows up as a count or flag mismatch. A reset issued while windows are in flight is also checked: the outputs must stay silent until a fresh window fills.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int MAX_SYM_W = 8;

  // Mismatch between two symbol codes (zero-extended to MAX_SYM_W).
  // comp = 0: mismatch when the codes differ.
  // comp = 1: match only when one code is the bitwise inverse of the other.
  function automatic logic sym_mismatch(input logic [MAX_SYM_W-1:0] a,
                                        input logic [MAX_SYM_W-1:0] b,
                                        input logic comp,
                                        input int w);
    logic [MAX_SYM_W-1:0] mask;
    mask = MAX_SYM_W'((1 << w) - 1);
    if (comp) return ((a ^ ~b) & mask) != '0;
    else      return ((a ^ b) & mask) != '0;
  endfunction

endpackage

// File: rtl/pal_window.sv
module pal_window #(
  parameter int SYM_W = 2,
  parameter int WIN   = 16,
  parameter int IDX_W = 16,
  parameter int CW    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [SYM_W-1:0]       in_sym,
  input  logic                   in_comp,
  input  logic [CW-1:0]          in_thresh,
  output logic                   w_valid,
  output logic                   w_comp,
  output logic [CW-1:0]          w_thresh,
  output logic [IDX_W-1:0]       w_start,
  output logic [WIN*SYM_W-1:0]   w_flat
);
  localparam int FILL_W = $clog2(WIN);

  // Shift register with no reset, so it can map to shift-register primitives.
  logic [SYM_W-1:0]  win [WIN];
  logic [FILL_W-1:0] fill;
  logic [IDX_W-1:0]  idx;
  logic              full;

  assign full = (fill == FILL_W'(WIN - 1));

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int i = 0; i < WIN - 1; i++) win[i] <= win[i+1];
      win[WIN-1] <= in_sym;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill     <= '0;
      idx      <= '0;
      w_valid  <= 1'b0;
      w_comp   <= 1'b0;
      w_thresh <= '0;
      w_start  <= '0;
    end else begin
      w_valid <= in_valid && full;
      if (in_valid) begin
        idx      <= idx + IDX_W'(1);
        if (!full) fill <= fill + FILL_W'(1);
        w_start  <= idx - IDX_W'(WIN - 1);
        w_comp   <= in_comp;
        w_thresh <= in_thresh;
      end
    end
  end

  for (genvar g = 0; g < WIN; g++) begin : g_flat
    assign w_flat[g*SYM_W +: SYM_W] = win[g];
  end

  // Two windows completed on consecutive edges start one symbol apart.
  p_start_step_r7: assert property (@(posedge clk) disable iff (rst)
    (w_valid && $past(w_valid)) |-> (w_start == $past(w_start) + IDX_W'(1)));

  // An idle input cycle never yields a window.
  p_idle_no_window_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !w_valid);

endmodule

// File: rtl/pal_compare.sv
module pal_compare
  import pal_pkg::*;
#(
  parameter int SYM_W = 2,
  parameter int WIN   = 16,
  parameter int IDX_W = 16,
  parameter int CW    = 4,
  localparam int H    = WIN / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 w_valid,
  input  logic                 w_comp,
  input  logic [CW-1:0]        w_thresh,
  input  logic [IDX_W-1:0]     w_start,
  input  logic [WIN*SYM_W-1:0] w_flat,
  output logic                 c_valid,
  output logic [H-1:0]         c_mism,
  output logic [CW-1:0]        c_thresh,
  output logic [IDX_W-1:0]     c_start
);
  logic [H-1:0] mism_d;

  // Pair j: j places left of centre against j places right of centre.
  for (genvar j = 1; j <= H; j++) begin : g_pair
    logic [SYM_W-1:0] lhs, rhs;
    assign lhs = w_flat[(H-j)*SYM_W +: SYM_W];
    assign rhs = w_flat[(H+j-1)*SYM_W +: SYM_W];
    assign mism_d[j-1] = sym_mismatch(MAX_SYM_W'(lhs), MAX_SYM_W'(rhs),
                                      w_comp, SYM_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid  <= 1'b0;
      c_mism   <= '0;
      c_thresh <= '0;
      c_start  <= '0;
    end else begin
      c_valid  <= w_valid;
      c_mism   <= mism_d;
      c_thresh <= w_thresh;
      c_start  <= w_start;
    end
  end

  // Compare results appear exactly one edge after their window.
  p_cmp_follow_r2: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> $past(w_valid));

endmodule

// File: rtl/pal_stage.sv
module pal_stage #(
  parameter int IDX_W = 16,
  parameter int CW    = 4,
  parameter int H     = 8,
  parameter int J     = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              p_valid,
  input  logic [H-1:0]      p_mism,
  input  logic [CW-1:0]     p_thresh,
  input  logic [IDX_W-1:0]  p_start,
  input  logic [CW-1:0]     p_sum,
  input  logic [H*CW-1:0]   p_counts,
  output logic              q_valid,
  output logic [H-1:0]      q_mism,
  output logic [CW-1:0]     q_thresh,
  output logic [IDX_W-1:0]  q_start,
  output logic [CW-1:0]     q_sum,
  output logic [H*CW-1:0]   q_counts
);
  logic [CW-1:0] sum_d;
  assign sum_d = p_sum + CW'(p_mism[J-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_mism   <= '0;
      q_thresh <= '0;
      q_start  <= '0;
      q_sum    <= '0;
      q_counts <= '0;
    end else begin
      q_valid  <= p_valid;
      q_mism   <= p_mism;
      q_thresh <= p_thresh;
      q_start  <= p_start;
      q_sum    <= sum_d;
      // Slot J-1 is still empty on arrival; tap the running sum into it.
      q_counts <= p_counts | ((H*CW)'(sum_d) << ((J - 1) * CW));
    end
  end

  // A half-length J window cannot hold more than J mismatching pairs.
  p_sum_bound_r3: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> (q_sum <= CW'(J)));

endmodule

// File: rtl/pal_flags.sv
module pal_flags #(
  parameter int IDX_W = 16,
  parameter int CW    = 4,
  parameter int H     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              f_valid,
  input  logic [H-1:0]      f_mism,
  input  logic [CW-1:0]     f_thresh,
  input  logic [IDX_W-1:0]  f_start,
  input  logic [CW-1:0]     f_sum,
  input  logic [H*CW-1:0]   f_counts,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_start,
  output logic [H*CW-1:0]   out_count,
  output logic [H-1:0]      out_flag
);
  logic [H-1:0] flag_d;

  for (genvar j = 0; j < H; j++) begin : g_flag
    assign flag_d[j] = (f_counts[j*CW +: CW] <= f_thresh);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_start <= '0;
      out_count <= '0;
      out_flag  <= '0;
    end else begin
      out_valid <= f_valid;
      out_start <= f_start;
      out_count <= f_counts;
      out_flag  <= flag_d;
    end
  end

  // The full-length total equals the number of failing pair compares.
  p_total_r3: assert property (@(posedge clk) disable iff (rst)
    f_valid |-> ((f_sum == CW'($countones(f_mism))) &&
                 (f_counts[(H-1)*CW +: CW] == f_sum)));

  // Nothing is reported on the first cycle after a reset.
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  for (genvar j = 1; j < H; j++) begin : g_mono
    logic [CW-1:0] cur, prv;
    assign cur = out_count[j*CW +: CW];
    assign prv = out_count[(j-1)*CW +: CW];

    p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((cur >= prv) && ((cur - prv) <= CW'(1))));

    // A longer length within threshold implies the shorter one is too.
    p_flag_mono_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_flag[j]) |-> out_flag[j-1]);
  end

endmodule

// File: rtl/pal_mirror_scan.sv
module pal_mirror_scan #(
  parameter int SYM_W = 2,
  parameter int WIN   = 16,
  parameter int IDX_W = 16,
  localparam int H    = WIN / 2,
  localparam int CW   = $clog2(H + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [SYM_W-1:0]  in_sym,
  input  logic              in_comp,
  input  logic [CW-1:0]     in_thresh,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_start,
  output logic [H*CW-1:0]   out_count,
  output logic [H-1:0]      out_flag
);
  logic                 w_valid, w_comp;
  logic [CW-1:0]        w_thresh;
  logic [IDX_W-1:0]     w_start;
  logic [WIN*SYM_W-1:0] w_flat;

  logic                 ch_valid  [H+1];
  logic [H-1:0]         ch_mism   [H+1];
  logic [CW-1:0]        ch_thresh [H+1];
  logic [IDX_W-1:0]     ch_start  [H+1];
  logic [CW-1:0]        ch_sum    [H+1];
  logic [H*CW-1:0]      ch_counts [H+1];

  pal_window #(.SYM_W(SYM_W), .WIN(WIN), .IDX_W(IDX_W), .CW(CW)) u_win (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sym(in_sym), .in_comp(in_comp), .in_thresh(in_thresh),
    .w_valid(w_valid), .w_comp(w_comp), .w_thresh(w_thresh),
    .w_start(w_start), .w_flat(w_flat)
  );

  pal_compare #(.SYM_W(SYM_W), .WIN(WIN), .IDX_W(IDX_W), .CW(CW)) u_cmp (
    .clk(clk), .rst(rst),
    .w_valid(w_valid), .w_comp(w_comp), .w_thresh(w_thresh),
    .w_start(w_start), .w_flat(w_flat),
    .c_valid(ch_valid[0]), .c_mism(ch_mism[0]),
    .c_thresh(ch_thresh[0]), .c_start(ch_start[0])
  );

  assign ch_sum[0]    = '0;
  assign ch_counts[0] = '0;

  for (genvar j = 1; j <= H; j++) begin : g_chain
    pal_stage #(.IDX_W(IDX_W), .CW(CW), .H(H), .J(j)) u_stage (
      .clk(clk), .rst(rst),
      .p_valid(ch_valid[j-1]), .p_mism(ch_mism[j-1]), .p_thresh(ch_thresh[j-1]),
      .p_start(ch_start[j-1]), .p_sum(ch_sum[j-1]), .p_counts(ch_counts[j-1]),
      .q_valid(ch_valid[j]), .q_mism(ch_mism[j]), .q_thresh(ch_thresh[j]),
      .q_start(ch_start[j]), .q_sum(ch_sum[j]), .q_counts(ch_counts[j])
    );
  end

  pal_flags #(.IDX_W(IDX_W), .CW(CW), .H(H)) u_flags (
    .clk(clk), .rst(rst),
    .f_valid(ch_valid[H]), .f_mism(ch_mism[H]), .f_thresh(ch_thresh[H]),
    .f_start(ch_start[H]), .f_sum(ch_sum[H]), .f_counts(ch_counts[H]),
    .out_valid(out_valid), .out_start(out_start),
    .out_count(out_count), .out_flag(out_flag)
  );

endmodule

// File: tb/tb_pal_mirror_scan.sv
module tb_pal_mirror_scan;
  localparam int CLK_P = 10;
  localparam int SYM_W = 2;
  localparam int WIN   = 8;
  localparam int IDX_W = 12;
  localparam int H     = WIN / 2;
  localparam int CW    = $clog2(H + 1);
  localparam int MASK  = (1 << SYM_W) - 1;
  localparam int LAT   = H + 3;  // negedge of drive to negedge where result shows

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_comp = 1'b0;
  logic [SYM_W-1:0] in_sym = '0;
  logic [CW-1:0] in_thresh = '0;
  logic out_valid;
  logic [IDX_W-1:0] out_start;
  logic [H*CW-1:0] out_count;
  logic [H-1:0] out_flag;

  pal_mirror_scan #(.SYM_W(SYM_W), .WIN(WIN), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sym(in_sym),
    .in_comp(in_comp), .in_thresh(in_thresh), .out_valid(out_valid),
    .out_start(out_start), .out_count(out_count), .out_flag(out_flag));

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0, nsym = 0;
  int hist [0:4095];
  bit exp_v [64];
  bit exp_m [64];
  logic [H*CW-1:0] exp_cnt [64];
  logic [H-1:0] exp_flag [64];
  logic [IDX_W-1:0] exp_start [64];
  string vtag = "R1";
  bit done = 1'b0;

  task automatic check_outputs();
    int s = cyc % 64;
    nchk++;
    if (out_valid !== exp_v[s]) begin
      nfail++;
      $display("FAIL %s out_valid actual %0b expected %0b", vtag, out_valid, exp_v[s]);
    end else if (exp_v[s]) begin
      nchk++;
      if (out_start !== exp_start[s]) begin
        nfail++;
        $display("FAIL R7 out_start actual %0d expected %0d", out_start, exp_start[s]);
      end
      nchk++;
      if (out_count !== exp_cnt[s]) begin
        nfail++;
        $display("FAIL R3 %s out_count actual %h expected %h",
                 exp_m[s] ? "R5" : "R4", out_count, exp_cnt[s]);
      end
      nchk++;
      if (out_flag !== exp_flag[s]) begin
        nfail++;
        $display("FAIL R6 out_flag actual %b expected %b", out_flag, exp_flag[s]);
      end
    end
    exp_v[s] = 1'b0;
  endtask

  task automatic record(input int n, input bit comp, input int thr);
    int s = (cyc + LAT) % 64;
    int st = n - WIN + 1;
    int sum = 0;
    for (int j = 1; j <= H; j++) begin
      int a = hist[st + H - j];
      int b = hist[st + H + j - 1];
      bit mm = comp ? (a != ((~b) & MASK)) : (a != b);
      sum += int'(mm);
      exp_cnt[s][(j-1)*CW +: CW] = CW'(sum);
      exp_flag[s][j-1] = (sum <= thr);
    end
    exp_start[s] = IDX_W'(st);
    exp_m[s] = comp;
    exp_v[s] = 1'b1;
  endtask

  task automatic step(input bit v, input int sym, input bit comp, input int thr);
    @(negedge clk);
    check_outputs();
    in_valid = v; in_sym = SYM_W'(sym); in_comp = comp; in_thresh = CW'(thr);
    if (v) begin
      hist[nsym] = sym & MASK;
      if (nsym >= WIN - 1) record(nsym, comp, thr);
      nsym++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
    nsym = 0;
  endtask

  // Half random, then mirrored (complemented in comp mode), optional corruption.
  task automatic pal_segment(input bit comp, input int thr, input int bad);
    int a [H];
    for (int i = 0; i < H; i++) begin
      a[i] = int'($urandom_range(MASK, 0));
      step(1'b1, a[i], comp, thr);
    end
    for (int i = H - 1; i >= 0; i--) begin
      int b = comp ? ((~a[i]) & MASK) : a[i];
      if (i == bad) b = b ^ 1;
      step(1'b1, b, comp, thr);
    end
  endtask

  initial begin
    do_reset();
    // R1: reset state and silent fill.
    vtag = "R1";
    @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0) begin
      nfail++; $display("FAIL R1 out_valid after reset actual %0b expected 0", out_valid);
    end
    for (int i = 0; i < WIN - 1; i++) step(1'b1, i & MASK, 1'b0, 1);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, 1'b0, 0);

    // R2/R4/R5/R6: random stream with gaps, per-symbol mode and threshold.
    vtag = "R2";
    for (int i = 0; i < 800; i++)
      step(($urandom_range(3, 0) != 0), int'($urandom_range(MASK, 0)),
           bit'($urandom_range(1, 0)), int'($urandom_range(H + 1, 0)));

    // R5/R4/R6: mirrored segments, every threshold, both modes, with and without a flaw.
    for (int thr = 0; thr <= H + 1; thr++)
      for (int m = 0; m < 2; m++)
        for (int bad = -1; bad < H; bad++)
          pal_segment(bit'(m), thr, bad);

    // Mixed settings back to back on mirrored data (settings carried per window).
    for (int i = 0; i < 30; i++)
      pal_segment(bit'(i & 1), i % (H + 2), (i % 3 == 0) ? -1 : i % H);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, 1'b0, 0);

    // R9: reset with results in flight.
    for (int i = 0; i < WIN + 3; i++) step(1'b1, int'($urandom_range(MASK, 0)), 1'b0, 2);
    do_reset();
    vtag = "R9";
    for (int i = 0; i < LAT + 4; i++) step(1'b0, 0, 1'b0, 0);
    vtag = "R1";
    for (int i = 0; i < WIN - 1; i++) step(1'b1, int'($urandom_range(MASK, 0)), 1'b1, 1);
    vtag = "R2";
    for (int i = 0; i < 40; i++) step(1'b1, int'($urandom_range(MASK, 0)), 1'b1, 1);
    for (int i = 0; i < LAT + 4; i++) step(1'b0, 0, 1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule